// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between peripherals and memory without the processor doing each transfer. Four channels each keep a 16-bit memory address and a 16-bit count word. A host sets them up through a byte-wide register port, selecting a register with four select lines. When an enabled channel sees its peripheral request, the controller raises a bus hold request to the processor. It takes over the bus only after the hold is acknowledged. Each transfer lasts one clock. During that clock the controller drives the memory address, the strobe pair for the transfer direction, and an active-low acknowledge for the channel being served.

The count word packs a 14-bit field that holds the transfer count minus one, and a 2-bit transfer type in its top bits. A terminal-count pulse marks the last transfer of a block, and a mark pulse repeats at a fixed spacing counted back from that last transfer. Channels are served in fixed or rotating priority order. An optional auto-load mode restarts channel 2 from the values held in channel 3. There is no streaming data path: every pin is a plain control or status signal, so no back-pressure rules apply.

Top module: `dma4_ctrl`

## Requirements
- R1: While `rst_n` is low, `hrq` is 0, all `dack_n` bits and all four strobes are 1, and `a_oe` is 0. Reset also clears the mode register, which disables every channel.
- R2: Select value `sel` below 8 picks channel `sel[2:1]`. `sel[0]`=0 picks the address register and `sel[0]`=1 picks the count register. Each 16-bit register is written and read as two byte accesses, low byte first, under a byte-pointer flip-flop. Each such access toggles the pointer, and a write to select 8 (mode) clears it.
- R3: The mode byte holds the per-channel enables in bits 3..0, rotating priority in bit 4 and auto-load in bit 7. With bit 4 clear, the lowest-numbered requesting channel wins.
- R4: With bit 4 set, the search starts at the channel after the one served last, so the channel just served has the lowest priority. After reset, channel 0 ranks first.
- R5: `hrq` rises in the cycle after an enabled channel requests. No acknowledge or strobe is driven before `hlda` has been sampled high.
- R6: In each one-clock transfer, exactly the served channel's `dack_n` bit is low.
- R7: Count bits 15..14 set the strobes. 10 drives `mem_rd_n` and `io_wr_n` low. 01 drives `io_rd_n` and `mem_wr_n` low. 00 (verify) and 11 drive no strobe.
- R8: During a transfer, `a_out` carries address bits 3..0 with `a_oe`=1, and `addr_hi` carries bits 15..4. After each transfer the address increments and the 14-bit count field decrements.
- R9: `tc` is high in the transfer whose count field is zero. The channel's status flag is then set, and the channel's enable is cleared unless auto-load applies.
- R10: `mark` is high in a transfer whose count field has its low `MARK_LOG2` bits all ones.
- R11: With auto-load on, channel 2 at terminal count loads its address and count from channel 3 and stays enabled.
- R12: Status bit 4 (update flag) is set by writing the high byte of channel 3's count while auto-load is on. It is cleared by a channel-2 reload, by a mode write with bit 7 clear, or by reset. A status read leaves it unchanged.
- R13: Reading select 8 returns the terminal-count flags in bits 3..0 and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| a_in | input | 4 | Register select lines while acting as slave |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| drq | input | NCH | Peripheral requests |
| hrq | output | 1 | Bus hold request |
| hlda | input | 1 | Bus hold acknowledge |
| dack_n | output | NCH | Active-low per-channel acknowledge |
| a_out | output | 4 | Low address nibble while acting as master |
| a_oe | output | 1 | Output enable for `a_out` |
| addr_hi | output | 12 | Address bits 15..4 while acting as master |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | Peripheral read strobe |
| io_wr_n | output | 1 | Peripheral write strobe |
| tc | output | 1 | Terminal-count pulse |
| mark | output | 1 | Periodic mark pulse |

## Verification
The bench builds the controller with the default four channels and with `MARK_LOG2` lowered to 3. A mark therefore falls every eighth transfer before terminal count, and an 11-transfer block shows one mark next to its terminal count within a few dozen clocks. The four-channel build covers the fixed and rotating priority orders, including rotation that resumes from the last channel served in an earlier block. It also covers the channel 3 to channel 2 reload and a held-off `hlda`.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
package dma4_pkg;
  localparam int ADDR_W   = 16;
  localparam int REG_W    = 16;
  localparam int CNT_W    = 14;
  localparam int SEL_MODE = 8;
  localparam int RL_DST   = 2;
  localparam int RL_SRC   = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} dma_st_e;
  typedef enum logic [1:0] {
    XT_VERIFY = 2'b00,
    XT_WRITE  = 2'b01,
    XT_READ   = 2'b10,
    XT_RSVD   = 2'b11
  } xfer_e;
endpackage

// File: rtl/dma4_chan.sv
`timescale 1ns/1ps
module dma4_chan
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_hi,
  input  logic [7:0]        wdata,
  input  logic              step,
  input  logic              reload,
  input  logic [ADDR_W-1:0] rl_addr,
  input  logic [REG_W-1:0]  rl_cnt,
  output logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  cnt
);
  // reload beats step beats host write; host writes never overlap a transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else if (reload) begin
      addr <= rl_addr;
      cnt  <= rl_cnt;
    end else if (step) begin
      addr <= addr + 1'b1;
      cnt[CNT_W-1:0] <= cnt[CNT_W-1:0] - 1'b1;
    end else begin
      if (wr_addr) begin
        if (wr_hi) addr[15:8] <= wdata;
        else       addr[7:0]  <= wdata;
      end
      if (wr_cnt) begin
        if (wr_hi) cnt[15:8] <= wdata;
        else       cnt[7:0]  <= wdata;
      end
    end
  end
endmodule

// File: rtl/dma4_arb.sv
`timescale 1ns/1ps
module dma4_arb #(
  parameter int NCH = 4,
  parameter int CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic [CW-1:0]  last,
  output logic [CW-1:0]  idx,
  output logic           vld
);
  int base;
  always_comb begin
    base = rotate ? ((int'(last) + 1) % NCH) : 0;
    idx  = '0;
    // walk from lowest priority to highest so the highest hit is kept
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[(base + i) % NCH]) idx = CW'((base + i) % NCH);
    end
    vld = |req;
  end
endmodule

// File: rtl/dma4_ctrl.sv
`timescale 1ns/1ps
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int MARK_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [3:0]        a_in,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [NCH-1:0]    drq,
  output logic              hrq,
  input  logic              hlda,
  output logic [NCH-1:0]    dack_n,
  output logic [3:0]        a_out,
  output logic              a_oe,
  output logic [ADDR_W-5:0] addr_hi,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              tc,
  output logic              mark
);
  localparam int CW = $clog2(NCH);

  dma_st_e         st_q;
  logic [CW-1:0]   g_q, last_q, arb_idx;
  logic            arb_vld;
  logic [NCH-1:0]  en_q, tcf_q, req;
  logic            rot_q, auto_q, ff_q, upd_q;
  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [REG_W-1:0]  ch_cnt  [NCH];

  logic host_ok, wr_go, rd_go, sel_ch, sel_mode;
  logic [CW-1:0] sel_idx;
  logic xfer, cur_tc, reload_hit, upd_set;
  logic [REG_W-1:0] cur_cnt, sel_reg;
  xfer_e cur_type;

  assign host_ok  = (st_q != ST_XFER);
  assign wr_go    = host_wr & host_ok;
  assign rd_go    = host_rd & host_ok & ~host_wr;
  assign sel_ch   = ~a_in[3];
  assign sel_mode = (a_in == 4'(SEL_MODE));
  assign sel_idx  = a_in[CW:1];

  assign req  = drq & en_q;
  assign xfer = (st_q == ST_XFER);

  assign cur_cnt    = ch_cnt[g_q];
  assign cur_tc     = (cur_cnt[CNT_W-1:0] == '0);
  assign cur_type   = xfer_e'(cur_cnt[REG_W-1:CNT_W]);
  assign reload_hit = xfer & cur_tc & auto_q & (g_q == CW'(RL_DST));
  assign upd_set    = wr_go & sel_ch & a_in[0] & ff_q & auto_q & (sel_idx == CW'(RL_SRC));

  dma4_arb #(.NCH(NCH), .CW(CW)) u_arb (
    .req(req), .rotate(rot_q), .last(last_q), .idx(arb_idx), .vld(arb_vld)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int SRC = (i == RL_DST) ? RL_SRC : i;
    logic hit;
    assign hit = wr_go & sel_ch & (sel_idx == CW'(i));
    dma4_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_addr(hit & ~a_in[0]), .wr_cnt(hit & a_in[0]), .wr_hi(ff_q),
      .wdata(host_wdata),
      .step(xfer & (g_q == CW'(i))),
      .reload(reload_hit & (i == RL_DST)),
      .rl_addr(ch_addr[SRC]), .rl_cnt(ch_cnt[SRC]),
      .addr(ch_addr[i]), .cnt(ch_cnt[i])
    );
  end

  // transfer sequencing: idle -> hold request -> one-clock transfer -> re-arbitrate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      g_q    <= '0;
      last_q <= '1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (arb_vld) st_q <= ST_REQ;
        ST_REQ: begin
          if (!arb_vld) st_q <= ST_IDLE;
          else if (hlda) begin
            st_q <= ST_XFER;
            g_q  <= arb_idx;
          end
        end
        ST_XFER: begin
          st_q   <= ST_REQ;
          last_q <= g_q;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // mode, flags and byte pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rot_q  <= 1'b0;
      auto_q <= 1'b0;
      ff_q   <= 1'b0;
      upd_q  <= 1'b0;
      tcf_q  <= '0;
    end else begin
      if (wr_go && sel_mode) begin
        en_q   <= host_wdata[NCH-1:0];
        rot_q  <= host_wdata[4];
        auto_q <= host_wdata[7];
        ff_q   <= 1'b0;
        if (!host_wdata[7]) upd_q <= 1'b0;
      end else begin
        if ((wr_go || rd_go) && sel_ch) ff_q <= ~ff_q;
        if (upd_set) upd_q <= 1'b1;
      end
      if (rd_go && sel_mode) tcf_q <= '0;
      if (xfer && cur_tc) begin
        tcf_q[g_q] <= 1'b1;
        if (reload_hit) upd_q <= 1'b0;
        else            en_q[g_q] <= 1'b0;
      end
    end
  end

  always_comb begin
    sel_reg    = a_in[0] ? ch_cnt[sel_idx] : ch_addr[sel_idx];
    host_rdata = '0;
    if (sel_mode) begin
      host_rdata[NCH-1:0] = tcf_q;
      host_rdata[4]       = upd_q;
    end else if (sel_ch) begin
      host_rdata = ff_q ? sel_reg[15:8] : sel_reg[7:0];
    end
  end

  always_comb begin
    hrq      = (st_q != ST_IDLE);
    dack_n   = '1;
    if (xfer) dack_n[g_q] = 1'b0;
    a_oe     = xfer;
    a_out    = xfer ? ch_addr[g_q][3:0] : 4'h0;
    addr_hi  = xfer ? ch_addr[g_q][ADDR_W-1:4] : '0;
    mem_rd_n = ~(xfer & (cur_type == XT_READ));
    io_wr_n  = ~(xfer & (cur_type == XT_READ));
    io_rd_n  = ~(xfer & (cur_type == XT_WRITE));
    mem_wr_n = ~(xfer & (cur_type == XT_WRITE));
    tc       = xfer & cur_tc;
    mark     = xfer & (&cur_cnt[MARK_LOG2-1:0]);
  end
endmodule

// File: rtl/dma4_chk.sv
`timescale 1ns/1ps
module dma4_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hlda,
  input logic           hrq,
  input logic [NCH-1:0] dack_n,
  input logic           a_oe,
  input logic           mem_rd_n,
  input logic           mem_wr_n,
  input logic           io_rd_n,
  input logic           io_wr_n,
  input logic           tc,
  input logic           mark
);
  a_r6_one_dack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  a_r5_master_after_hlda: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_n != '1) |-> $past(hlda));

  a_r7_strobe_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    !((!mem_rd_n && !mem_wr_n) || (!io_rd_n && !io_wr_n)));

  a_r8_oe_only_master: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe |-> (hrq && dack_n != '1));

  a_r9_tc_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (dack_n != '1));

  a_r10_mark_not_tc: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> (!tc && a_oe));
endmodule

bind dma4_ctrl dma4_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hlda(hlda), .hrq(hrq), .dack_n(dack_n),
  .a_oe(a_oe), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc), .mark(mark)
);

// File: tb/tb_dma4_ctrl.sv
`timescale 1ns/1ps
module tb_dma4_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, host_wr = 1'b0, host_rd = 1'b0, hlda = 1'b0;
  logic [3:0] a_in = '0, drq = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic hrq, a_oe, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc, mark;
  logic [3:0] dack_n, a_out;
  logic [11:0] addr_hi;

  dma4_ctrl #(.NCH(4), .MARK_LOG2(3)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .a_in(a_in),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .drq(drq), .hrq(hrq),
    .hlda(hlda), .dack_n(dack_n), .a_out(a_out), .a_oe(a_oe), .addr_hi(addr_hi),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .tc(tc), .mark(mark)
  );

  int n_chk = 0, n_fail = 0;
  bit hold_block = 0, done = 0;
  int served[$], served_addr[$];
  int mark_cnt = 0, tc_cnt = 0, rds_cnt = 0, wrs_cnt = 0;

  // behavioural reference model
  int m_addr[4], m_cnt[4];
  int m_en, m_rot, m_auto, m_ff, m_upd, m_tcf, m_st, m_g, m_last;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int pick(int reqs);
    int base = m_rot ? (m_last + 1) % 4 : 0;
    for (int i = 0; i < 4; i++)
      if (reqs[(base + i) % 4]) return (base + i) % 4;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int g, c14, reqs, sel, d, ch;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_cnt[i] = 0; end
      m_en = 0; m_rot = 0; m_auto = 0; m_ff = 0; m_upd = 0; m_tcf = 0;
      m_st = 0; m_g = 0; m_last = 3;
    end else if (m_st == 2) begin
      g = m_g;
      c14 = m_cnt[g] & 'h3fff;
      m_addr[g] = (m_addr[g] + 1) & 'hffff;
      m_cnt[g] = (m_cnt[g] & 'hc000) | ((c14 - 1) & 'h3fff);
      if (c14 == 0) begin
        m_tcf = m_tcf | (1 << g);
        if (g == 2 && m_auto != 0) begin
          m_addr[2] = m_addr[3]; m_cnt[2] = m_cnt[3]; m_upd = 0;
        end else m_en = m_en & ~(1 << g);
      end
      m_last = g;
      m_st = 1;
    end else begin
      reqs = int'(drq) & m_en;
      sel = int'(a_in); d = int'(host_wdata);
      if (host_wr) begin
        if (sel == 8) begin
          m_en = d & 15; m_rot = (d >> 4) & 1; m_auto = (d >> 7) & 1; m_ff = 0;
          if (m_auto == 0) m_upd = 0;
        end else if (sel < 8) begin
          ch = sel >> 1;
          if (sel & 1) begin
            m_cnt[ch] = m_ff ? ((m_cnt[ch] & 'hff) | (d << 8)) : ((m_cnt[ch] & 'hff00) | d);
            if (ch == 3 && m_ff != 0 && m_auto != 0) m_upd = 1;
          end else
            m_addr[ch] = m_ff ? ((m_addr[ch] & 'hff) | (d << 8)) : ((m_addr[ch] & 'hff00) | d);
          m_ff ^= 1;
        end
      end else if (host_rd) begin
        if (sel == 8) m_tcf = 0;
        else if (sel < 8) m_ff ^= 1;
      end
      if (m_st == 0) begin
        if (reqs != 0) m_st = 1;
      end else begin
        if (reqs == 0) m_st = 0;
        else if (hlda) begin m_g = pick(reqs); m_st = 2; end
      end
    end
  end

  // CPU side: grants hold one cycle after the request
  initial forever begin
    @(negedge clk);
    hlda = hrq && !hold_block;
  end

  // per-clock comparison against the model
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      bit xf; int g, ty, c14;
      xf = (m_st == 2); g = m_g; ty = (m_cnt[g] >> 14) & 3; c14 = m_cnt[g] & 'h3fff;
      chk(hrq == (m_st != 0), "R5 hrq", hrq, m_st != 0);
      chk(int'(dack_n) == (xf ? (~(1 << g) & 15) : 15), "R6 dack_n (R3 R4 order)",
          dack_n, xf ? (~(1 << g) & 15) : 15);
      chk({mem_rd_n, io_wr_n, io_rd_n, mem_wr_n} ==
          {!(xf && ty == 2), !(xf && ty == 2), !(xf && ty == 1), !(xf && ty == 1)},
          "R7 strobes", {mem_rd_n, io_wr_n, io_rd_n, mem_wr_n}, ty);
      chk(a_oe == xf && int'(a_out) == (xf ? (m_addr[g] & 15) : 0) &&
          int'(addr_hi) == (xf ? (m_addr[g] >> 4) : 0), "R8 address",
          {addr_hi, a_out}, xf ? m_addr[g] : 0);
      chk(tc == (xf && c14 == 0), "R9 tc", tc, xf && c14 == 0);
      chk(mark == (xf && (c14 & 7) == 7), "R10 mark", mark, xf && (c14 & 7) == 7);
      if (dack_n != 4'hF) begin
        for (int i = 0; i < 4; i++) if (!dack_n[i]) served.push_back(i);
        served_addr.push_back({addr_hi, a_out});
      end
      if (mark) mark_cnt++;
      if (tc) tc_cnt++;
      if (!mem_rd_n) rds_cnt++;
      if (!mem_wr_n) wrs_cnt++;
    end
  end

  task automatic wr(int sel, int d);
    @(negedge clk);
    a_in = 4'(sel); host_wdata = 8'(d); host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wr16(int sel, int v);
    wr(sel, v & 255);
    wr(sel, (v >> 8) & 255);
  endtask

  task automatic rd(int sel, int exp, string tag);
    int mexp;
    @(negedge clk);
    a_in = 4'(sel); host_rd = 1'b1;
    #2;
    if (sel == 8) mexp = (m_upd << 4) | m_tcf;
    else if (sel < 8) mexp = ((sel & 1) ? m_cnt[sel >> 1] : m_addr[sel >> 1]) >> (m_ff ? 8 : 0);
    else mexp = 0;
    mexp &= 255;
    chk(int'(host_rdata) == mexp, "R2 readback vs model", host_rdata, mexp);
    if (exp >= 0) chk(int'(host_rdata) == exp, tag, host_rdata, exp);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    for (int k = 0; k < 5000; k++) begin
      if (!hrq) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_counts();
    served.delete(); served_addr.delete();
    mark_cnt = 0; tc_cnt = 0; rds_cnt = 0; wrs_cnt = 0;
  endtask

  initial begin
    int exp_rot[8] = '{2, 3, 0, 1, 2, 3, 0, 1};
    int exp_fix[4] = '{0, 0, 1, 1};
    int exp_fa[4]  = '{'h100, 'h101, 'h200, 'h201};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(hrq == 1'b0, "R1 hrq in reset", hrq, 0);
    chk(dack_n == 4'hF, "R1 dack_n in reset", dack_n, 'hF);
    chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF, "R1 strobes in reset",
        {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 'hF);
    chk(a_oe == 1'b0, "R1 a_oe in reset", a_oe, 0);
    rst_n = 1'b1;

    // R2 byte access and byte pointer
    wr16(2, 'hBEEF);
    rd(2, 'hEF, "R2 low byte");
    rd(2, 'hBE, "R2 high byte");
    wr(0, 'h11); wr(8, 0); wr(0, 'h22); wr(0, 'h33);
    rd(0, 'h22, "R2 pointer cleared by mode write low");
    rd(0, 'h33, "R2 pointer cleared by mode write high");

    // R3 fixed priority, R7 read and write types
    wr16(0, 'h0100); wr16(1, 'h8001); wr16(2, 'h0200); wr16(3, 'h4001);
    clear_counts();
    wr(8, 'h03);
    drq = 4'h3;
    wait_idle();
    drq = 4'h0;
    chk(served.size() == 4, "R3 fixed transfer count", served.size(), 4);
    foreach (exp_fix[i]) if (i < served.size()) begin
      chk(served[i] == exp_fix[i], "R3 fixed order", served[i], exp_fix[i]);
      chk(served_addr[i] == exp_fa[i], "R8 address sequence", served_addr[i], exp_fa[i]);
    end
    chk(rds_cnt == 2 && wrs_cnt == 2, "R7 strobe cycles", {rds_cnt, wrs_cnt}, 'h2_0000_0002);
    rd(8, 'h03, "R9 tc flags set");
    rd(8, 'h00, "R13 flags cleared by read");
    rd(0, 'h02, "R8 address advanced low");
    rd(0, 'h01, "R8 address advanced high");

    // R4 rotating priority resumes after channel 1
    wr16(0, 'h1000); wr16(1, 1); wr16(2, 'h2000); wr16(3, 1);
    wr16(4, 'h3000); wr16(5, 1); wr16(6, 'h4000); wr16(7, 1);
    clear_counts();
    wr(8, 'h1F);
    drq = 4'hF;
    wait_idle();
    drq = 4'h0;
    chk(served.size() == 8, "R4 rotating transfer count", served.size(), 8);
    foreach (exp_rot[i]) if (i < served.size())
      chk(served[i] == exp_rot[i], "R4 rotating order", served[i], exp_rot[i]);
    chk(rds_cnt == 0 && wrs_cnt == 0, "R7 verify has no strobes", rds_cnt + wrs_cnt, 0);
    chk(tc_cnt == 4, "R9 one tc per channel", tc_cnt, 4);
    rd(8, 'h0F, "R13 all flags");

    // R10 mark spacing with MARK_LOG2 = 3
    wr16(0, 0); wr16(1, 'h800A);
    clear_counts();
    wr(8, 'h01);
    drq = 4'h1;
    wait_idle();
    drq = 4'h0;
    chk(served.size() == 11, "R8 count minus one", served.size(), 11);
    chk(mark_cnt == 1, "R10 mark pulses", mark_cnt, 1);
    chk(tc_cnt == 1, "R9 single tc", tc_cnt, 1);
    rd(8, 'h01, "R13 ch0 flag");

    // R11 and R12 auto-load
    wr(8, 'h84);
    wr16(4, 'h0400); wr16(5, 'h8000); wr16(6, 'h0500); wr16(7, 'h8000);
    rd(8, 'h10, "R12 update flag set");
    rd(8, 'h10, "R12 status read keeps flag");
    clear_counts();
    drq = 4'h4;
    for (int k = 0; k < 200; k++) begin
      if (served.size() >= 3) break;
      @(negedge clk);
    end
    drq = 4'h0;
    wait_idle();
    chk(served.size() >= 3, "R11 channel 2 keeps running", served.size(), 3);
    if (served_addr.size() >= 2) begin
      chk(served_addr[0] == 'h0400, "R11 first block address", served_addr[0], 'h400);
      chk(served_addr[1] == 'h0500, "R11 reloaded address", served_addr[1], 'h500);
    end
    rd(8, 'h04, "R12 flag cleared by reload");
    rd(4, 'h00, "R11 ch2 address low");
    rd(4, 'h05, "R11 ch2 address high");
    wr(8, 'h84); wr16(7, 'h8000);
    rd(8, 'h10, "R12 set again");
    wr(8, 'h04);
    rd(8, 'h00, "R12 cleared by mode write");

    // R5 no master operation without hlda
    wr(8, 0); wr16(0, 0); wr16(1, 0); wr(8, 'h01);
    clear_counts();
    hold_block = 1;
    drq = 4'h1;
    repeat (10) @(negedge clk);
    #2;
    chk(hrq == 1'b1, "R5 hold requested", hrq, 1);
    chk(dack_n == 4'hF && served.size() == 0, "R5 waits for hlda", dack_n, 'hF);
    hold_block = 0;
    wait_idle();
    drq = 4'h0;
    chk(served.size() == 1, "R5 transfer after hlda", served.size(), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog: got 0 expected 1 (run did not complete)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule